// File: doc/BRIEF.md
# I2C 10-Bit Slave Address Matcher

This block is the addressing front end of an I2C target that answers to a 10-bit address. The raw SCL and SDA lines are brought into the system clock domain by a synchroniser. Condition logic then finds START, repeated START and STOP on the synchronised lines. The address comes in two bytes. The first carries the fixed prefix `11110`, the upper two address bits and the R/W bit. The second carries the lower eight bits. The block acknowledges each byte that matches by pulling SDA low through an open-drain enable.

Once the full address has been received with a write bit, the block hands the bus to a byte-level data engine in receive mode. It raises an addressed flag and holds SCL low until software acknowledges the flag. The match is remembered. A repeated START followed by a first byte with the read bit then moves the block to transmit mode without the low byte being sent again. The block takes part in the bus only when the host role is off and 10-bit addressing is selected.

Top module: `i2c_addr10_slave`

## Requirements
- R1: After reset `sda_oe`, `scl_hold`, `start_flag` and `tx_mode` are all 0.
- R2: Each line passes two synchroniser flops and one edge-history flop. A START is an SDA fall while SCL is high. A STOP is an SDA rise while SCL is high. Data bits are sampled on SCL rising edges, MSB first.
- R3: A first byte `11110 a9 a8 0` whose a9 a8 equal `own_addr[9:8]` is acknowledged. `sda_oe` is 1 from the SCL fall after bit 8 to the SCL fall after the ninth clock.
- R4: A first byte whose top five bits are not `11110`, or whose a9 a8 differ from `own_addr[9:8]`, is not acknowledged. Later bytes are ignored until the next START.
- R5: After an acknowledged write first byte, a second byte equal to `own_addr[7:0]` is acknowledged. At the end of that ninth clock `start_flag` goes to 1 and `tx_mode` to 0. A mismatching second byte is not acknowledged and leaves `start_flag` at 0.
- R6: After a full 10-bit match, a repeated START and a matching first byte with R/W = 1 are acknowledged. At the end of the ninth clock `tx_mode` goes to 1 and `start_flag` to 1.
- R7: A first byte with R/W = 1 that arrives with no remembered full match is not acknowledged. A STOP clears the remembered match and `tx_mode`.
- R8: `scl_hold` is 1 exactly while `start_flag` is 1. A `start_ack` pulse clears both on the next clock.
- R9: While `host_mode` = 1 or `wide_addr_en` = 0 the block stays idle. It gives no acknowledge and holds all outputs at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| host_mode | input | 1 | 1 when the channel acts as bus controller; disables this block |
| wide_addr_en | input | 1 | 1 selects 10-bit target addressing |
| own_addr | input | 10 | Own 10-bit address |
| start_ack | input | 1 | Software pulse that services the addressed flag |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| scl_hold | output | 1 | 1 pulls SCL low (clock stretch) |
| start_flag | output | 1 | Addressed status flag |
| tx_mode | output | 1 | Transfer direction: 1 transmit, 0 receive |

## Verification
The bench goes after the read-without-prior-match case. A design that ignored the memory bit would acknowledge an unrelated target's read. It also checks that a STOP erases the memory, since a design that kept it would answer reads in later transfers. Header mismatches are driven in both the prefix and the upper address bits, followed by a trailing byte. A design that stayed in the address sequence would acknowledge that trailing byte. A wrong low byte and both disable inputs are also tried. Every clock, the acknowledge window and the stretch release are compared against a reference model. This catches a design whose acknowledge starts or stops one SCL edge early or late, or whose flag outlives `start_ack`.

// File: rtl/i2c10_pkg.sv
package i2c10_pkg;
    localparam int ADDR_W = 10;
    localparam int BYTE_W = 8;
    localparam int HI_W   = ADDR_W - BYTE_W;
    localparam int CNT_W  = $clog2(BYTE_W);
    localparam logic [BYTE_W-HI_W-2:0] HDR_PREFIX = 5'b11110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_HDR_ACK,
        ST_LOW,
        ST_LOW_ACK,
        ST_BUSY
    } st_e;

    typedef struct packed {
        st_e               st;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] shreg;
        logic              ack_go;
        logic              is_read;
        logic              sda_oe;
        logic              matched;
        logic              tx;
        logic              flag;
    } ctx_t;
endpackage

// File: rtl/i2c10_sync.sv
module i2c10_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/i2c10_cond.sv
module i2c10_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_det,
    output logic stop_det,
    output logic scl_rise,
    output logic scl_fall
);
    logic scl_p_q, sda_p_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p_q <= 1'b1;
            sda_p_q <= 1'b1;
        end else begin
            scl_p_q <= scl_s;
            sda_p_q <= sda_s;
        end
    end

    assign start_det = scl_s & scl_p_q & sda_p_q & ~sda_s;
    assign stop_det  = scl_s & scl_p_q & ~sda_p_q & sda_s;
    assign scl_rise  = scl_s & ~scl_p_q;
    assign scl_fall  = ~scl_s & scl_p_q;
endmodule

// File: rtl/i2c_addr10_slave.sv
module i2c_addr10_slave
    import i2c10_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              host_mode,
    input  logic              wide_addr_en,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              start_ack,
    output logic              sda_oe,
    output logic              scl_hold,
    output logic              start_flag,
    output logic              tx_mode
);
    logic [1:0] line_s;
    logic scl_s, sda_s;
    logic start_det, stop_det, scl_rise, scl_fall;
    logic enable;
    logic [BYTE_W-1:0] byte_in;
    logic hdr_ok;
    ctx_t d, q;

    i2c10_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(line_s)
    );
    assign scl_s = line_s[1];
    assign sda_s = line_s[0];

    i2c10_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .start_det(start_det), .stop_det(stop_det),
        .scl_rise(scl_rise), .scl_fall(scl_fall)
    );

    assign enable  = ~host_mode & wide_addr_en;
    assign byte_in = {q.shreg[BYTE_W-2:0], sda_s};
    assign hdr_ok  = (byte_in[BYTE_W-1:HI_W+1] == HDR_PREFIX)
                   && (byte_in[HI_W:1] == own_addr[ADDR_W-1:BYTE_W])
                   && (!byte_in[0] || q.matched);

    always_comb begin
        d = q;
        if (start_ack) d.flag = 1'b0;
        if (!enable) begin
            d = '0;
        end else if (start_det) begin
            d.st     = ST_HDR;
            d.cnt    = '0;
            d.sda_oe = 1'b0;
            d.ack_go = 1'b0;
        end else if (stop_det) begin
            d.st      = ST_IDLE;
            d.sda_oe  = 1'b0;
            d.matched = 1'b0;
            d.tx      = 1'b0;
        end else begin
            case (q.st)
                ST_HDR, ST_LOW: begin
                    if (scl_rise) begin
                        d.shreg = byte_in;
                        d.cnt   = CNT_W'(q.cnt + 1'b1);
                        if (q.cnt == CNT_W'(BYTE_W - 1)) begin
                            if (q.st == ST_HDR) begin
                                d.st      = ST_HDR_ACK;
                                d.is_read = byte_in[0];
                                d.ack_go  = hdr_ok;
                            end else begin
                                d.st     = ST_LOW_ACK;
                                d.ack_go = (byte_in == own_addr[BYTE_W-1:0]);
                            end
                        end
                    end
                end
                ST_HDR_ACK, ST_LOW_ACK: begin
                    if (scl_fall) begin
                        if (!q.sda_oe) begin
                            if (q.ack_go) begin
                                d.sda_oe = 1'b1;
                            end else begin
                                d.st      = ST_IDLE;
                                d.matched = 1'b0;
                            end
                        end else begin
                            d.sda_oe = 1'b0;
                            if (q.st == ST_HDR_ACK && !q.is_read) begin
                                d.st  = ST_LOW;
                                d.cnt = '0;
                            end else begin
                                d.st   = ST_BUSY;
                                d.flag = 1'b1;
                                d.tx   = (q.st == ST_HDR_ACK);
                                if (q.st == ST_LOW_ACK) d.matched = 1'b1;
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sda_oe     = q.sda_oe;
    assign scl_hold   = q.flag;
    assign start_flag = q.flag;
    assign tx_mode    = q.tx;

    AST_ACK_IN_ACK_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (q.st == ST_HDR_ACK || q.st == ST_LOW_ACK)); // R3
    AST_FLAG_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_flag) |-> $past(sda_oe)); // R5
    AST_READ_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_mode) |-> $past(q.matched)); // R6
    AST_STOP_FORGETS: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && enable) |=> (!q.matched && !tx_mode)); // R7
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!sda_oe && !start_flag && !tx_mode)); // R9
endmodule

// File: tb/i2c_addr10_slave_bench.sv
module i2c_addr10_slave_bench;
    localparam int PH = 6;
    localparam logic [9:0] OWN = 10'h2A5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic host_mode = 1'b0, wide_en = 1'b1, start_ack = 1'b0;
    logic sda_oe, scl_hold, start_flag, tx_mode;
    wire  scl_bus = m_scl & ~scl_hold;
    wire  sda_bus = m_sda & ~sda_oe;

    int checks = 0, errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    i2c_addr10_slave u_i2c_addr10_slave (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_bus), .sda_in(sda_bus),
        .host_mode(host_mode), .wide_addr_en(wide_en), .own_addr(OWN),
        .start_ack(start_ack), .sda_oe(sda_oe), .scl_hold(scl_hold),
        .start_flag(start_flag), .tx_mode(tx_mode)
    );

    // Behavioural reference model: line history queue plus integer phase tracking
    int  ms, mcnt, mbyte;
    bit  mgo, moe, mmatch, mtx, mflag, mrd, en;
    bit [1:0] hist[$];
    bit [1:0] cur, prv, now;

    always @(posedge clk) begin
        if (!rst_n) begin
            ms = 0; mcnt = 0; mbyte = 0; mgo = 0; moe = 0;
            mmatch = 0; mtx = 0; mflag = 0; mrd = 0;
            hist = '{2'b11, 2'b11, 2'b11};
        end else begin
            prv = hist[0];
            cur = hist[1];
            now = {m_scl & ~mflag, m_sda & ~moe};
            en = !host_mode && wide_en;
            if (start_ack) mflag = 0;
            if (!en) begin
                ms = 0; mcnt = 0; mbyte = 0; mgo = 0; moe = 0;
                mmatch = 0; mtx = 0; mflag = 0; mrd = 0;
            end else if (cur[1] && prv[1] && prv[0] && !cur[0]) begin
                ms = 1; mcnt = 0; moe = 0; mgo = 0;
            end else if (cur[1] && prv[1] && !prv[0] && cur[0]) begin
                ms = 0; moe = 0; mmatch = 0; mtx = 0;
            end else if ((ms == 1 || ms == 3) && cur[1] && !prv[1]) begin
                mbyte = ((mbyte << 1) | cur[0]) & 255;
                mcnt++;
                if (mcnt == 8) begin
                    mcnt = 0;
                    if (ms == 1) begin
                        mrd = mbyte[0];
                        mgo = ((mbyte >> 3) == 30) && (((mbyte >> 1) & 3) == OWN[9:8])
                              && (!mrd || mmatch);
                        ms = 2;
                    end else begin
                        mgo = (mbyte == OWN[7:0]);
                        ms = 4;
                    end
                end
            end else if ((ms == 2 || ms == 4) && !cur[1] && prv[1]) begin
                if (!moe) begin
                    if (mgo) moe = 1;
                    else begin ms = 0; mmatch = 0; end
                end else begin
                    moe = 0;
                    if (ms == 2 && !mrd) begin ms = 3; mcnt = 0; end
                    else begin
                        mflag = 1;
                        mtx = (ms == 2);
                        if (ms == 4) mmatch = 1;
                        ms = 5;
                    end
                end
            end
            hist.push_back(now);
            void'(hist.pop_front());
        end
    end

    // Per-clock comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (sda_oe !== moe) begin errors++;
                $display("FAIL R2 R3 R4 sda_oe actual %0b expected %0b", sda_oe, moe); end
            if (scl_hold !== mflag) begin errors++;
                $display("FAIL R8 scl_hold actual %0b expected %0b", scl_hold, mflag); end
            if (start_flag !== mflag) begin errors++;
                $display("FAIL R5 start_flag actual %0b expected %0b", start_flag, mflag); end
            if (tx_mode !== mtx) begin errors++;
                $display("FAIL R6 tx_mode actual %0b expected %0b", tx_mode, mtx); end
        end
    end

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic wc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic scl_up();
        m_scl = 1'b1;
        while (!scl_bus) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wc(PH); scl_up(); wc(PH);
        m_sda = 1'b0; wc(PH); m_scl = 1'b0; wc(PH);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wc(PH); scl_up(); wc(PH);
        m_sda = 1'b1; wc(PH);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = v[i]; wc(PH); scl_up(); wc(PH); m_scl = 1'b0; wc(PH);
        end
        m_sda = 1'b1; wc(PH); scl_up(); wc(PH / 2);
        acked = ~sda_bus;
        wc(PH / 2); m_scl = 1'b0; wc(PH);
    endtask

    task automatic service();
        start_ack = 1'b1; wc(1); start_ack = 1'b0; wc(2);
    endtask

    logic ak;

    initial begin
        wc(3);
        rst_n = 1'b1;
        wc(1);
        chk(sda_oe, 1'b0, "R1 sda_oe after reset");
        chk(scl_hold, 1'b0, "R1 scl_hold after reset");
        chk(start_flag, 1'b0, "R1 start_flag after reset");
        chk(tx_mode, 1'b0, "R1 tx_mode after reset");
        wc(10);

        // full write addressing
        bus_start();
        send_byte(8'hF4, ak); chk(ak, 1'b1, "R3 header write ack");
        send_byte(8'hA5, ak); chk(ak, 1'b1, "R5 low byte ack");
        wc(4);
        chk(start_flag, 1'b1, "R5 flag after addressing");
        chk(tx_mode, 1'b0, "R5 receive direction");
        chk(scl_hold, 1'b1, "R8 stretch while flag set");
        chk(scl_bus, 1'b0, "R8 SCL held low on bus");
        service();
        chk(start_flag, 1'b0, "R8 flag cleared by start_ack");
        chk(scl_hold, 1'b0, "R8 stretch released");

        // repeated START with read header
        bus_start();
        send_byte(8'hF5, ak); chk(ak, 1'b1, "R6 read header ack after match");
        wc(4);
        chk(tx_mode, 1'b1, "R6 transmit direction");
        chk(start_flag, 1'b1, "R6 flag on read addressing");
        service();
        bus_stop();
        wc(4);
        chk(tx_mode, 1'b0, "R7 STOP clears direction");

        // read header with memory cleared
        bus_start();
        send_byte(8'hF5, ak); chk(ak, 1'b0, "R7 read without prior match NACK");
        bus_stop();

        // header mismatches
        bus_start();
        send_byte(8'hF6, ak); chk(ak, 1'b0, "R4 upper bits mismatch NACK");
        send_byte(8'hA5, ak); chk(ak, 1'b0, "R4 trailing byte ignored");
        bus_start();
        send_byte(8'h74, ak); chk(ak, 1'b0, "R4 bad prefix NACK");
        bus_stop();

        // low byte mismatch
        bus_start();
        send_byte(8'hF4, ak); chk(ak, 1'b1, "R3 header ack before low mismatch");
        send_byte(8'hA4, ak); chk(ak, 1'b0, "R5 low byte mismatch NACK");
        wc(4);
        chk(start_flag, 1'b0, "R5 no flag on mismatch");
        bus_start();
        send_byte(8'hF5, ak); chk(ak, 1'b0, "R7 read after failed match NACK");
        bus_stop();

        // disabled modes
        wide_en = 1'b0; wc(4);
        bus_start();
        send_byte(8'hF4, ak); chk(ak, 1'b0, "R9 seven-bit mode ignores header");
        send_byte(8'hA5, ak); chk(ak, 1'b0, "R9 seven-bit mode ignores low byte");
        chk(start_flag, 1'b0, "R9 no flag when disabled");
        bus_stop();
        wide_en = 1'b1; host_mode = 1'b1; wc(4);
        bus_start();
        send_byte(8'hF4, ak); chk(ak, 1'b0, "R9 host mode ignores header");
        bus_stop();
        host_mode = 1'b0; wc(4);

        // re-enabled: addressing works again
        bus_start();
        send_byte(8'hF4, ak); chk(ak, 1'b1, "R3 header ack after re-enable");
        send_byte(8'hA5, ak); chk(ak, 1'b1, "R5 low byte ack after re-enable");
        wc(4);
        service();
        bus_stop();
        wc(10);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL R2 watchdog actual still running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule